// File: doc/BRIEF.md
# Row-Buffered Program Memory Self-Write Controller

This block lets a processor program its own program memory one row at a time. Software writes a word address and a data word into byte-wide registers. It unlocks the controller with a two-byte key and then sets a start bit in the control register. In latch-load mode each start copies one data word into a row buffer. In commit mode a start copies the whole buffer into the memory row picked by the upper address bits. During the commit the processor is frozen by a stall output for a programmable number of cycles.

The memory array and the row buffer are modelled inside the block as plain registers. A cycle counter stands in for the programming time. A word register pair lets software read back any array word at the current address.

The sequencer has six named states:
- SQ_IDLE waits for an accepted start and moves to SQ_LATCH in latch-load mode, or to SQ_GRACE in commit mode.
- SQ_LATCH writes one buffer word and returns to SQ_IDLE.
- SQ_GRACE lets GRACE_SLOTS processor cycles run and then moves to SQ_COPY.
- SQ_COPY moves one buffer word per cycle into the array. After the last word it goes to SQ_HOLD, or straight to SQ_FINISH when there is no remaining time.
- SQ_HOLD spends the rest of PROG_CYCLES and then moves to SQ_FINISH.
- SQ_FINISH refills the buffer, clears the start bit and returns to SQ_IDLE.

The key tracker has three states: UL_IDLE, UL_HALF (first key byte seen) and UL_ARMED.

Top module: `flash_selfwrite_ctrl`

## Requirements
- R1: Register offsets are: 0 address low, 1 address high, 2 data low, 3 data high, 4 control, 5 key, 6 array word low byte (read), 7 array word high bits (read). A start is accepted only if the last two writes to offset 5 were 55h and then AAh. Writes to other offsets may fall between them. Any other key order is ignored.
- R2: Control bit 0 (write enable) must be 1 in the same control write that sets bit 1 (start), or the start is ignored.
- R3: A start written with control bit 3 (configuration space) set to 1 is ignored.
- R4: Every control write with bit 1 set, accepted or not, returns the key tracker to idle, so a second start needs a fresh key pair.
- R5: With control bit 2 set to 1, an accepted start stores the data word in the buffer slot chosen by the low COL_W address bits and leaves the array unchanged. Control bit 1 then reads 1 for exactly one cycle.
- R6: With control bit 2 at 0, an accepted start writes all ROW_WORDS buffer slots into the array row given by the address bits above COL_W. Every other row stays unchanged.
- R7: The data word is {data_high, data_low} truncated to DATA_W bits, so the top bits of the high byte are dropped.
- R8: After an accepted commit, cpu_stall stays 0 for GRACE_SLOTS cycles and is then 1 for exactly PROG_CYCLES cycles.
- R9: Control bit 1 reads 1 from acceptance until the operation ends and then clears itself. A start written while an operation runs is ignored.
- R10: After reset and after every commit, all buffer slots hold all ones, so a slot that was not loaded programs all ones.
- R11: After reset, the control register reads 0, cpu_stall is 0 and every array word reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| cpu_stall | output | 1 | Freezes the processor during a commit |

## Verification
The bench sweeps every slot of every row of a small configuration. Each row has one slot left unloaded, and the expected array image is computed by arithmetic.

Key handling is tested with several bad patterns:
- a missing key;
- the key bytes in reverse order;
- a stray byte written to the key register between the two key bytes;
- a start with write enable clear;
- a start with configuration space selected;
- a reused key.

A design that arms too easily would put those words into the array, and a design that reuses the key would accept the second start. Two allowed patterns must still arm: a repeated first key byte, and a data register write between the key bytes. The bench counts the stall window cycle by cycle, so an off-by-one in the grace or hold counter shows up as a wrong length. A load attempted during a running commit must leave the buffer untouched. A missing buffer refill after a commit shows up as stale words in a later row.

// File: rtl/fsw_pkg.sv
package fsw_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LATCH,
        SQ_GRACE,
        SQ_COPY,
        SQ_HOLD,
        SQ_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        UL_IDLE,
        UL_HALF,
        UL_ARMED
    } key_state_t;

    localparam logic [2:0] OFF_ADR_LO = 3'd0;
    localparam logic [2:0] OFF_ADR_HI = 3'd1;
    localparam logic [2:0] OFF_DAT_LO = 3'd2;
    localparam logic [2:0] OFF_DAT_HI = 3'd3;
    localparam logic [2:0] OFF_CTRL   = 3'd4;
    localparam logic [2:0] OFF_KEY    = 3'd5;
    localparam logic [2:0] OFF_ARR_LO = 3'd6;
    localparam logic [2:0] OFF_ARR_HI = 3'd7;

    localparam int BIT_WREN  = 0;
    localparam int BIT_START = 1;
    localparam int BIT_LOAD  = 2;
    localparam int BIT_CFG   = 3;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

endpackage

// File: rtl/fsw_unlock.sv
module fsw_unlock
    import fsw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    input  logic       attempt,
    output logic       armed
);

    key_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (attempt) begin
            st_d = UL_IDLE;
        end else if (key_wr) begin
            if (key_data == KEY_FIRST)
                st_d = UL_HALF;
            else if (key_data == KEY_SECOND && st_q == UL_HALF)
                st_d = UL_ARMED;
            else
                st_d = UL_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= UL_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        armed = (st_q == UL_ARMED);
    end

    assert_arm_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == UL_ARMED && $past(st_q) != UL_ARMED) |->
            ($past(st_q) == UL_HALF && $past(key_wr) && $past(key_data) == KEY_SECOND));

    assert_attempt_disarms_R4: assert property (@(posedge clk) disable iff (!rst_n)
        attempt |=> (st_q == UL_IDLE));

endmodule

// File: rtl/fsw_latches.sv
module fsw_latches #(
    parameter int WORDS = 32,
    parameter int DW    = 14,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [IW-1:0] ld_idx,
    input  logic [DW-1:0] ld_data,
    input  logic          preset,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] slot_q [WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n || preset) begin
            for (int i = 0; i < WORDS; i++) slot_q[i] <= '1;
        end else if (ld_en) begin
            slot_q[ld_idx] <= ld_data;
        end
    end

    always_comb begin
        rd_data = slot_q[rd_idx];
    end

    assert_load_preset_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_en && preset));

endmodule

// File: rtl/fsw_array.sv
module fsw_array #(
    parameter int DEPTH = 512,
    parameter int DW    = 14,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= '1;
        end else if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = cell_q[raddr];
    end

endmodule

// File: rtl/flash_selfwrite_ctrl.sv
module flash_selfwrite_ctrl
    import fsw_pkg::*;
#(
    parameter int ROWS        = 16,
    parameter int ROW_WORDS   = 32,
    parameter int DATA_W      = 14,
    parameter int PROG_CYCLES = 64,
    parameter int GRACE_SLOTS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_we,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       cpu_stall
);

    localparam int COL_W       = $clog2(ROW_WORDS);
    localparam int ROW_W       = $clog2(ROWS);
    localparam int ADDR_W      = COL_W + ROW_W;
    localparam int DEPTH       = ROWS * ROW_WORDS;
    localparam int HOLD_CYCLES = PROG_CYCLES - ROW_WORDS;
    localparam int CNT_W       = $clog2(PROG_CYCLES + GRACE_SLOTS + 1);

    // ---------------- register file ----------------
    logic [7:0] adr_lo_q, adr_hi_q, dat_lo_q, dat_hi_q;
    logic       wren_q, load_q, cfg_q, go_q;

    logic wr_ctrl, wr_key, attempt, accept, armed;

    always_comb begin
        wr_ctrl = bus_we && (bus_addr == OFF_CTRL);
        wr_key  = bus_we && (bus_addr == OFF_KEY);
        attempt = wr_ctrl && bus_wdata[BIT_START];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adr_lo_q <= '0;
            adr_hi_q <= '0;
            dat_lo_q <= '0;
            dat_hi_q <= '0;
            wren_q   <= 1'b0;
            load_q   <= 1'b0;
            cfg_q    <= 1'b0;
        end else if (bus_we) begin
            unique case (bus_addr)
                OFF_ADR_LO: adr_lo_q <= bus_wdata;
                OFF_ADR_HI: adr_hi_q <= bus_wdata;
                OFF_DAT_LO: dat_lo_q <= bus_wdata;
                OFF_DAT_HI: dat_hi_q <= bus_wdata;
                OFF_CTRL: begin
                    wren_q <= bus_wdata[BIT_WREN];
                    load_q <= bus_wdata[BIT_LOAD];
                    cfg_q  <= bus_wdata[BIT_CFG];
                end
                default: ;
            endcase
        end
    end

    // ---------------- address and data shaping ----------------
    logic [15:0]        adr_full, dat_full;
    logic [ADDR_W-1:0]  word_addr;
    logic [COL_W-1:0]   col_sel;
    logic [ROW_W-1:0]   row_sel;
    logic [DATA_W-1:0]  data_word;

    always_comb begin
        adr_full  = {adr_hi_q, adr_lo_q};
        dat_full  = {dat_hi_q, dat_lo_q};
        word_addr = adr_full[ADDR_W-1:0];
        col_sel   = word_addr[COL_W-1:0];
        row_sel   = word_addr[ADDR_W-1:COL_W];
        data_word = dat_full[DATA_W-1:0];
    end

    // ---------------- key tracker ----------------
    fsw_unlock u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (wr_key),
        .key_data (bus_wdata),
        .attempt  (attempt),
        .armed    (armed)
    );

    // ---------------- sequencer ----------------
    seq_state_t        st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [ROW_W-1:0]  row_q;

    always_comb begin
        accept = attempt && armed && bus_wdata[BIT_WREN]
               && !bus_wdata[BIT_CFG] && (st_q == SQ_IDLE);
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            SQ_IDLE: begin
                cnt_d = '0;
                if (accept)
                    st_d = bus_wdata[BIT_LOAD] ? SQ_LATCH : SQ_GRACE;
            end
            SQ_LATCH: st_d = SQ_IDLE;
            SQ_GRACE: begin
                if (cnt_q == CNT_W'(GRACE_SLOTS - 1)) begin
                    st_d  = SQ_COPY;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            SQ_COPY: begin
                if (cnt_q == CNT_W'(ROW_WORDS - 1)) begin
                    st_d  = (HOLD_CYCLES == 0) ? SQ_FINISH : SQ_HOLD;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            SQ_HOLD: begin
                if (cnt_q == CNT_W'(HOLD_CYCLES - 1)) begin
                    st_d  = SQ_FINISH;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            SQ_FINISH: st_d = SQ_IDLE;
            default:   st_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SQ_IDLE;
            cnt_q <= '0;
            row_q <= '0;
            go_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (accept) begin
                row_q <= row_sel;
                go_q  <= 1'b1;
            end else if (st_q == SQ_LATCH || st_q == SQ_FINISH) begin
                go_q  <= 1'b0;
            end
        end
    end

    // ---------------- outputs of the sequencer ----------------
    logic              lat_ld, lat_preset, arr_we;
    logic [COL_W-1:0]  copy_idx;
    logic [ADDR_W-1:0] arr_waddr;

    always_comb begin
        lat_ld     = 1'b0;
        lat_preset = 1'b0;
        arr_we     = 1'b0;
        cpu_stall  = 1'b0;
        unique case (st_q)
            SQ_LATCH:  lat_ld     = 1'b1;
            SQ_COPY: begin
                arr_we    = 1'b1;
                cpu_stall = 1'b1;
            end
            SQ_HOLD:   cpu_stall  = 1'b1;
            SQ_FINISH: lat_preset = 1'b1;
            default: ;
        endcase
        copy_idx  = cnt_q[COL_W-1:0];
        arr_waddr = {row_q, copy_idx};
    end

    // ---------------- storage ----------------
    logic [DATA_W-1:0] lat_rd, arr_rd;

    fsw_latches #(
        .WORDS (ROW_WORDS),
        .DW    (DATA_W)
    ) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (lat_ld),
        .ld_idx  (col_sel),
        .ld_data (data_word),
        .preset  (lat_preset),
        .rd_idx  (copy_idx),
        .rd_data (lat_rd)
    );

    fsw_array #(
        .DEPTH (DEPTH),
        .DW    (DATA_W)
    ) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (lat_rd),
        .raddr (word_addr),
        .rdata (arr_rd)
    );

    // ---------------- read mux ----------------
    logic [15:0] arr_ext;

    always_comb begin
        arr_ext = 16'(arr_rd);
        unique case (bus_addr)
            OFF_ADR_LO: bus_rdata = adr_lo_q;
            OFF_ADR_HI: bus_rdata = adr_hi_q;
            OFF_DAT_LO: bus_rdata = dat_lo_q;
            OFF_DAT_HI: bus_rdata = dat_hi_q;
            OFF_CTRL:   bus_rdata = {4'b0000, cfg_q, load_q, go_q, wren_q};
            OFF_KEY:    bus_rdata = 8'h00;
            OFF_ARR_LO: bus_rdata = arr_ext[7:0];
            OFF_ARR_HI: bus_rdata = arr_ext[15:8];
            default:    bus_rdata = 8'h00;
        endcase
    end

    // ---------------- assertions ----------------
    assert_start_needs_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(go_q) |-> $past(armed));

    assert_start_needs_wren_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(go_q) |-> wren_q);

    assert_cfg_space_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(go_q) |-> !cfg_q);

    assert_stall_within_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> go_q);

    assert_busy_holds_go_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (go_q && (st_q == SQ_GRACE || st_q == SQ_COPY || st_q == SQ_HOLD)) |=> go_q);

    assert_array_quiet_in_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lat_ld |-> !arr_we);

endmodule

// File: tb/sim_flash_selfwrite_ctrl.sv
module sim_flash_selfwrite_ctrl;

    localparam int ROWS  = 4;
    localparam int RW    = 8;
    localparam int DW    = 14;
    localparam int PROG  = 12;
    localparam int GRACE = 2;
    localparam int NW    = ROWS * RW;
    localparam logic [13:0] ONES = 14'h3FFF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cpu_stall;

    int n_checks = 0;
    int n_fail   = 0;

    logic [13:0] exp_arr [NW];
    logic [13:0] exp_lat [RW];

    always #4 clk = ~clk;

    flash_selfwrite_ctrl #(
        .ROWS        (ROWS),
        .ROW_WORDS   (RW),
        .DATA_W      (DW),
        .PROG_CYCLES (PROG),
        .GRACE_SLOTS (GRACE)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cpu_stall (cpu_stall)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic bus_wr(input logic [2:0] off, input logic [7:0] v);
        bus_addr  = off;
        bus_wdata = v;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] off, output logic [7:0] v);
        bus_we   = 1'b0;
        bus_addr = off;
        #1;
        v = bus_rdata;
    endtask

    task automatic go_bit(output logic g);
        logic [7:0] v;
        bus_rd(3'd4, v);
        g = v[1];
    endtask

    task automatic key_pair();
        bus_wr(3'd5, 8'h55);
        bus_wr(3'd5, 8'hAA);
    endtask

    task automatic set_adr(input int a);
        bus_wr(3'd0, 8'(a));
    endtask

    task automatic set_dat(input logic [13:0] w);
        bus_wr(3'd2, w[7:0]);
        bus_wr(3'd3, {2'b11, w[13:8]});
    endtask

    task automatic wait_idle();
        logic g;
        for (int i = 0; i < 200; i++) begin
            go_bit(g);
            if (!g) break;
            @(negedge clk);
        end
    endtask

    // valid latch load; R5 go pulse, R7 data shaping via later readback
    task automatic load_word(input int a, input logic [13:0] w);
        logic g;
        set_adr(a);
        set_dat(w);
        key_pair();
        bus_wr(3'd4, 8'h07);
        go_bit(g);
        check(g == 1'b1, "R5 go high during load", int'(g), 1);
        @(negedge clk);
        go_bit(g);
        check(g == 1'b0, "R5 go clears after load", int'(g), 0);
        exp_lat[a % RW] = w;
    endtask

    // valid commit with stall window measurement (R8, R9, R6, R10)
    task automatic commit_row(input int r);
        int n;
        logic g;
        set_adr(r * RW);
        key_pair();
        bus_wr(3'd4, 8'h03);
        check(cpu_stall == 1'b0, "R8 no stall in grace slot 1", int'(cpu_stall), 0);
        @(negedge clk);
        check(cpu_stall == 1'b0, "R8 no stall in grace slot 2", int'(cpu_stall), 0);
        @(negedge clk);
        n = 0;
        while (cpu_stall && n < 1000) begin
            n++;
            @(negedge clk);
        end
        check(n == PROG, "R8 stall length", n, PROG);
        @(negedge clk);
        go_bit(g);
        check(g == 1'b0, "R9 go self-clears", int'(g), 0);
        for (int i = 0; i < RW; i++) begin
            exp_arr[r * RW + i] = exp_lat[i];
            exp_lat[i] = ONES;
        end
    endtask

    task automatic verify_all(input string req);
        logic [7:0] lo, hi;
        logic [13:0] w;
        for (int a = 0; a < NW; a++) begin
            set_adr(a);
            bus_rd(3'd6, lo);
            bus_rd(3'd7, hi);
            w = {hi[5:0], lo};
            check(w == exp_arr[a] && hi[7:6] == 2'b00, req, int'({hi, lo}), int'(exp_arr[a]));
            @(negedge clk);
        end
    endtask

    task automatic expect_ignored(input string req);
        logic g;
        go_bit(g);
        check(g == 1'b0, req, int'(g), 0);
        @(negedge clk);
    endtask

    function automatic logic [13:0] pat(input int r, input int i);
        return 14'((r * 1237 + i * 389 + 5) ^ (i << 10) ^ (r << 12));
    endfunction

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic g;
        for (int a = 0; a < NW; a++) exp_arr[a] = ONES;
        for (int i = 0; i < RW; i++) exp_lat[i] = ONES;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        bus_rd(3'd4, v);
        check(v == 8'h00, "R11 control after reset", int'(v), 0);
        check(cpu_stall == 1'b0, "R11 stall after reset", int'(cpu_stall), 0);
        verify_all("R11 array erased after reset");

        // R6 R7 R10 sweep: every slot of every row, one slot per row left unloaded
        for (int r = 0; r < ROWS - 1; r++) begin
            for (int i = 0; i < RW; i++) begin
                if (i != (r + 3) % RW) load_word(r * RW + i, pat(r, i));
            end
            commit_row(r);
            verify_all("R6 row commit image");
        end

        // R9: a load attempted during a running commit is ignored
        load_word(2 * RW + 1, 14'h0ABC);
        set_adr(2 * RW);
        key_pair();
        bus_wr(3'd4, 8'h03);
        set_dat(14'h1234);
        key_pair();
        bus_wr(3'd4, 8'h07);
        wait_idle();
        for (int i = 0; i < RW; i++) begin
            exp_arr[2 * RW + i] = exp_lat[i];
            exp_lat[i] = ONES;
        end
        commit_row(2);
        verify_all("R9 load during busy ignored, R10 refill");

        // key handling tests on row 3
        // slot0: no key at all (R1)
        set_adr(3 * RW + 0); set_dat(14'h0101);
        bus_wr(3'd4, 8'h07);
        expect_ignored("R1 start without key");
        // slot1: reversed key (R1)
        set_adr(3 * RW + 1); set_dat(14'h0202);
        bus_wr(3'd5, 8'hAA); bus_wr(3'd5, 8'h55);
        bus_wr(3'd4, 8'h07);
        expect_ignored("R1 reversed key");
        // slot2: stray key byte between (R1)
        set_adr(3 * RW + 2); set_dat(14'h0303);
        bus_wr(3'd5, 8'h55); bus_wr(3'd5, 8'h00); bus_wr(3'd5, 8'hAA);
        bus_wr(3'd4, 8'h07);
        expect_ignored("R1 interrupted key");
        // slot3: enable clear (R2), then reuse of consumed key (R4)
        set_adr(3 * RW + 3); set_dat(14'h0404);
        key_pair();
        bus_wr(3'd4, 8'h06);
        expect_ignored("R2 start with enable clear");
        bus_wr(3'd4, 8'h07);
        expect_ignored("R4 key consumed by failed attempt");
        // slot4: configuration space (R3)
        set_adr(3 * RW + 4); set_dat(14'h0505);
        key_pair();
        bus_wr(3'd4, 8'h0F);
        expect_ignored("R3 configuration space start");
        // slot5: valid load, then second start without fresh key (R4)
        load_word(3 * RW + 5, 14'h2A5A);
        set_dat(14'h1111);
        bus_wr(3'd4, 8'h07);
        expect_ignored("R4 second start needs new key");
        // slot6: repeated first byte still arms (R1)
        set_adr(3 * RW + 6); set_dat(14'h3C3C);
        bus_wr(3'd5, 8'h55); bus_wr(3'd5, 8'h55); bus_wr(3'd5, 8'hAA);
        bus_wr(3'd4, 8'h07);
        go_bit(g);
        check(g == 1'b1, "R1 repeated first key byte arms", int'(g), 1);
        exp_lat[6] = 14'h3C3C;
        @(negedge clk);
        // slot7: data write between key bytes still arms (R1)
        set_adr(3 * RW + 7);
        bus_wr(3'd5, 8'h55);
        set_dat(14'h0F0F);
        bus_wr(3'd5, 8'hAA);
        bus_wr(3'd4, 8'h07);
        go_bit(g);
        check(g == 1'b1, "R1 other-register write between key bytes", int'(g), 1);
        exp_lat[7] = 14'h0F0F;
        @(negedge clk);
        // R5: the loads so far must not have touched the array
        verify_all("R5 array unchanged by loads");
        commit_row(3);
        verify_all("R1 R2 R3 R4 key tests row image");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule